// File: doc/BRIEF.md
# Falling-Edge Flag Interrupt Register

This block gives a processor a single register for one edge-sensitive input line, such as the read line of a tape drive. The line is brought into the clock domain through a short synchronizer chain. Only a high-to-low transition is recorded, and it is recorded as a latched status bit. Software never sees the live level of the line, and it never sees rising transitions.

The register has one address, and it behaves differently for reads and writes. A read returns the pending status bits together with a summary bit that shows whether any pending bit is enabled. The same read clears everything that was pending. A write leaves the status bits alone and changes the enable mask instead. The top bit of the written byte selects the write mode: when it is 1, the mask bits written as 1 are set; when it is 0, the mask bits written as 1 are cleared.

An active-low request line stays asserted for as long as an enabled status bit is latched. This lets software either poll the status or take an interrupt on each edge.

Top module: `edge_irq_reg`

## Requirements
- R1: After reset every status bit and every mask bit is 0, irqN is 1, and a read returns 0x00.
- R2: A falling edge on flagIn sets status bit 4 whatever the mask holds. The bit becomes visible on the third rising clock edge after flagIn goes low.
- R3: A rising edge on flagIn has no effect on the register or on irqN, and neither does a level held low or high: a read after either returns 0x00 once earlier status has been cleared.
- R4: A write with bit 7 = 1 sets each mask bit whose written bit is 1. Mask bits written as 0 keep their value.
- R5: A write with bit 7 = 0 clears each mask bit whose written bit is 1. Mask bits written as 0 keep their value.
- R6: A write never changes the status bits.
- R7: A read returns the status in bits 4..0, returns 0 in bits 6..5, and returns 1 in bit 7 exactly when some status bit and its mask bit are both 1.
- R8: A read clears all status bits on its clock edge. Unless a new edge arrives, irqN is 1 after that edge.
- R9: An edge that sets status on the same clock edge as a clearing read is kept, and the next read reports it.
- R10: irqN is 0 exactly while some status bit and its mask bit are both 1. It stays 0 until a read or a mask clear removes that condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flagIn | input | 1 | Asynchronous edge-sensitive input line |
| regSel | input | 1 | Register select |
| regWr | input | 1 | Write strobe (mask update) |
| regRd | input | 1 | Read strobe (status read and clear) |
| wrData | input | DATA_W | Write value: bit 7 is the mode, bits 4..0 are the mask bits |
| rdData | output | DATA_W | Read value: bit 7 is the summary, bits 4..0 are the status |
| irqN | output | 1 | Active-low interrupt request |

## Verification
The bench uses the default parameters: an 8-bit data path, five status bits, the flag at bit 4, and two synchronizer stages. With those values, all 256 write values can be swept from both starting states of the flag's mask bit, and the expected mask is computed from the mode bit for each one. Every sweep step latches an edge before the write, so that one step covers the mask rules, status holding across writes, the read format, the clear on read, and the silence of levels and rising edges. A separately timed sequence places a new edge exactly on the clock edge of a clearing read.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  // Strobes issued by the control decode to the register datapath
  typedef struct packed {
    logic rdClr;   // clear status on this clock edge
    logic wrSet;   // OR written bits into mask
    logic wrClr;   // remove written bits from mask
  } regStrobe_t;
endpackage

// File: rtl/edge_irq_sync.sv
module edge_irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic fallPulse
);
  localparam int TAPS = STAGES + 1;

  logic [TAPS-1:0] chainQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chainQ[0] <= 1'b0;
    else       chainQ[0] <= lineIn;
  end

  for (genvar i = 1; i < TAPS; i++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chainQ[i] <= 1'b0;
      else       chainQ[i] <= chainQ[i-1];
    end
  end

  // previous sample high, current synchronized sample low
  assign fallPulse = chainQ[TAPS-1] & ~chainQ[TAPS-2];
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import edge_irq_pkg::*;
(
  input  logic       regSel,
  input  logic       regWr,
  input  logic       regRd,
  input  logic       modeBit,
  output regStrobe_t strb
);
  logic wrHit;
  assign wrHit = regSel & regWr;

  always_comb begin
    strb.rdClr = regSel & regRd;
    strb.wrSet = wrHit & modeBit;
    strb.wrClr = wrHit & ~modeBit;
  end
endmodule

// File: rtl/edge_irq_dp.sv
module edge_irq_dp
  import edge_irq_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         strb,
  input  logic [NUM_SRC-1:0] wrBits,
  input  logic [NUM_SRC-1:0] srcSet,
  output logic [NUM_SRC-1:0] statusQ,
  output logic [NUM_SRC-1:0] maskQ,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqN
);
  localparam int SUM_BIT = DATA_W - 1;

  logic [NUM_SRC-1:0] statusD;
  logic [NUM_SRC-1:0] maskD;
  logic               anyActive;

  always_comb begin
    statusD = strb.rdClr ? '0 : statusQ;
    statusD = statusD | srcSet;   // a new edge survives a clearing read
  end

  always_comb begin
    maskD = maskQ;
    if (strb.wrSet) maskD = maskQ | wrBits;
    if (strb.wrClr) maskD = maskQ & ~wrBits;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= '0;
    end else begin
      statusQ <= statusD;
      maskQ   <= maskD;
    end
  end

  assign anyActive = |(statusQ & maskQ);
  assign irqN      = ~anyActive;

  always_comb begin
    rdData                = '0;
    rdData[NUM_SRC-1:0]   = statusQ;
    rdData[SUM_BIT]       = anyActive;
  end
endmodule

// File: rtl/edge_irq_reg.sv
module edge_irq_reg
  import edge_irq_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int NUM_SRC     = 5,
  parameter int FLAG_IDX    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flagIn,
  input  logic              regSel,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqN
);
  localparam int MODE_BIT = DATA_W - 1;

  regStrobe_t         strb;
  logic               fallPulse;
  logic [NUM_SRC-1:0] srcSet;
  logic [NUM_SRC-1:0] statusQ;
  logic [NUM_SRC-1:0] maskQ;

  edge_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .lineIn(flagIn), .fallPulse(fallPulse)
  );

  // only the flag position has an event source in this block
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (i == FLAG_IDX) begin : g_flag
      assign srcSet[i] = fallPulse;
    end else begin : g_idle
      assign srcSet[i] = 1'b0;
    end
  end

  edge_irq_ctrl u_ctrl (
    .regSel(regSel), .regWr(regWr), .regRd(regRd),
    .modeBit(wrData[MODE_BIT]), .strb(strb)
  );

  edge_irq_dp #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wrBits(wrData[NUM_SRC-1:0]), .srcSet(srcSet),
    .statusQ(statusQ), .maskQ(maskQ),
    .rdData(rdData), .irqN(irqN)
  );
endmodule

// File: rtl/edge_irq_reg_chk.sv
module edge_irq_reg_chk #(
  parameter int DATA_W  = 8,
  parameter int NUM_SRC = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic               regSel,
  input logic               regWr,
  input logic               regRd,
  input logic [DATA_W-1:0]  wrData,
  input logic [DATA_W-1:0]  rdData,
  input logic               irqN,
  input logic [NUM_SRC-1:0] statusQ,
  input logic [NUM_SRC-1:0] maskQ
);
  logic wrOnly;
  assign wrOnly = regSel && regWr && !regRd;

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && regWr && wrData[DATA_W-1]) |=>
      ((maskQ & $past(wrData[NUM_SRC-1:0])) == $past(wrData[NUM_SRC-1:0]))); // R4

  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && regWr && !wrData[DATA_W-1]) |=>
      ((maskQ & $past(wrData[NUM_SRC-1:0])) == '0)); // R5

  AST_MASK_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && regWr) |=>
      (((maskQ ^ $past(maskQ)) & ~$past(wrData[NUM_SRC-1:0])) == '0)); // R4

  AST_MASK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !(regSel && regWr) |=> $stable(maskQ)); // R5

  AST_WRITE_HOLDS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    wrOnly |=> (($past(statusQ) & ~statusQ) == '0)); // R6

  AST_SUMMARY_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && regRd) |-> (rdData[DATA_W-1] == !irqN)); // R10
endmodule

bind edge_irq_reg edge_irq_reg_chk #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regRd(regRd),
  .wrData(wrData), .rdData(rdData), .irqN(irqN),
  .statusQ(statusQ), .maskQ(maskQ)
);

// File: tb/edge_irq_reg_bench.sv
module edge_irq_reg_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       flagIn = 1'b1;
  logic       regSel = 1'b0;
  logic       regWr = 1'b0;
  logic       regRd = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       irqN;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  edge_irq_reg u_edge_irq_reg (
    .clk(clk), .rstN(rstN), .flagIn(flagIn), .regSel(regSel),
    .regWr(regWr), .regRd(regRd), .wrData(wrData),
    .rdData(rdData), .irqN(irqN)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic writeReg(input logic [7:0] v);
    regSel = 1'b1; regWr = 1'b1; wrData = v;
    @(posedge clk); @(negedge clk);
    regSel = 1'b0; regWr = 1'b0; wrData = 8'h00;
  endtask

  task automatic readReg(input string req, input logic [7:0] exp);
    regSel = 1'b1; regRd = 1'b1;
    #1 chk(req, rdData, exp);
    @(posedge clk); @(negedge clk);
    regSel = 1'b0; regRd = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(4);
    // R1 reset state
    chk("R1 irqN", {7'd0, irqN}, 8'h01);
    readReg("R1 read", 8'h00);

    // sweep: start mask bit 4 in both states, all write values
    for (int start = 0; start < 2; start++) begin
      for (int v = 0; v < 256; v++) begin
        logic m4;
        logic [7:0] wv;
        wv = 8'(v);
        m4 = wv[7] ? (start[0] | wv[4]) : (start[0] & ~wv[4]);
        writeReg(8'h10);
        if (start == 1) writeReg(8'h90);
        flagIn = 1'b0;
        cyc(3);
        chk("R2 R10 irq after edge", {7'd0, irqN}, {7'd0, ~start[0]});
        writeReg(wv);
        chk("R4 R5 R10 irq after write", {7'd0, irqN}, {7'd0, ~m4});
        cyc(2);
        chk("R10 irq held", {7'd0, irqN}, {7'd0, ~m4});
        readReg("R6 R7 status read", {m4, 2'b00, 5'b10000});
        chk("R8 irq released", {7'd0, irqN}, 8'h01);
        cyc(2);
        readReg("R3 low level", 8'h00);
        flagIn = 1'b1;
        cyc(4);
        readReg("R3 rising edge", 8'h00);
        chk("R3 irq quiet", {7'd0, irqN}, 8'h01);
      end
    end

    // R9 edge on the same clock edge as a clearing read
    writeReg(8'h90);
    flagIn = 1'b0;
    cyc(3);
    flagIn = 1'b1;
    cyc(4);
    flagIn = 1'b0;
    cyc(2);
    regSel = 1'b1; regRd = 1'b1;
    #1 chk("R9 first read", rdData, 8'h90);
    @(posedge clk); @(negedge clk);
    regSel = 1'b0; regRd = 1'b0;
    chk("R9 irq still low", {7'd0, irqN}, 8'h00);
    readReg("R9 edge kept", 8'h90);
    chk("R8 irq after second read", {7'd0, irqN}, 8'h01);
    flagIn = 1'b1;
    cyc(4);

    // R5 mask clear drops a held request
    flagIn = 1'b0;
    cyc(3);
    chk("R10 irq pending", {7'd0, irqN}, 8'h00);
    writeReg(8'h10);
    chk("R5 R10 clear releases irq", {7'd0, irqN}, 8'h01);
    readReg("R6 R7 status kept", 8'h10);
    flagIn = 1'b1;
    cyc(4);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule